// File: doc/BRIEF.md
# Timebase, Capture and Watchdog Timer

This peripheral sits on a byte-wide microcontroller register bus and combines three timing services that share one prescaled counter. A free-running 8-bit up-counter advances once every 32 clock cycles and wraps after 249, so it overflows every 8000 cycles. Each overflow, or every second one in the long mode, raises a timebase flag that can request an interrupt. The same counter is the time reference for input capture. Either edge on the external capture pin, after a two-flop synchronizer, copies the counter into a read-only capture register.

A watchdog runs on a period of two overflows (16000 cycles). When it is enabled, software must set a delay bit during every period, or a one-cycle reset request is issued at the end of the period. Software can also force that request directly. The watchdog flag records that a watchdog reset happened. Only the block's power-on reset (`rst_n`) and the low-voltage reset input clear it, and a watchdog reset does not, so the flag still shows the cause after the reset.

Both event flags are cleared by read side effects and not by writes. A pending capture blocks further captures until software reads the capture register.

Top module: `tbcw_timer`

## Requirements
- R1: After reset the control/status register reads 0x00, the capture register reads 0x00, and `tb_irq_o`, `cap_irq_o` and `wdg_rst_o` are all 0.
- R2: The control/status register is at bus address 0x0B with bit 7 capture interrupt enable, bit 6 capture flag, bit 5 long-period select, bit 4 timebase interrupt enable, bit 3 timebase flag, bit 2 watchdog reset flag, bit 1 watchdog enable and bit 0 watchdog delay. The capture register is at 0x0C. Reads of any other address return 0x00.
- R3: The counter advances once every 32 clock cycles and wraps from 249 to 0. Counted in clock edges since reset release, its value is (edges / 32) mod 250.
- R4: The timebase flag is set on each overflow (every 8000 cycles) when bit 5 is 0. It is set on every second overflow (every 16000 cycles) when bit 5 is 1.
- R5: A read of the control/status register clears the timebase flag. Writing 1 to bit 3 does not set it.
- R6: When the capture flag is clear, any change of level on `cap_pin_i` copies the counter value into the capture register and sets the capture flag. The counter value used is the one 2 cycles after the pin changes. Both results are readable 3 cycles after the pin changes.
- R7: While the capture flag is set, pin edges leave the capture register unchanged. Only a read of the capture register clears the flag, and writes to bit 6 have no effect.
- R8: `tb_irq_o` is 1 exactly when the timebase flag and bit 4 are both 1. `cap_irq_o` is 1 exactly when the capture flag and bit 7 are both 1.
- R9: The watchdog period ends on every second overflow (every 16000 cycles). With bit 1 set and bit 0 clear at that point, `wdg_rst_o` is high for exactly that one cycle and the watchdog flag is set. With bit 1 clear, no request is made.
- R10: Writing 1 to bit 0 sets the delay bit, and writing 0 does not clear it. The end of each watchdog period clears it. If it is set when a period ends, the reset request for that period is skipped.
- R11: Writing 1 to bit 2 raises `wdg_rst_o` for one cycle in the next cycle and sets the watchdog flag. This works whether or not the watchdog is enabled.
- R12: A write with bit 2 at 0 clears the watchdog flag only if the previous control/status access was a read. A high cycle on `lvr_i` clears the flag unconditionally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| lvr_i | input | 1 | Low-voltage reset indication, clears the watchdog flag |
| bus_sel_i | input | 1 | Bus access select |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (read side effects take effect at the clock edge) |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from address |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| tb_irq_o | output | 1 | Timebase interrupt request |
| cap_irq_o | output | 1 | Capture interrupt request |
| wdg_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
Register writes and read side effects take effect at the clock edge that ends the access cycle, so they become visible one cycle later. A pin change shows up in the capture register and the capture interrupt three cycles later. The overflow events (timebase flag, interrupt and watchdog request) appear at exactly multiples of 8000 or 16000 edges after reset release. The bench keeps its own edge count from reset release and samples on falling edges at those computed cycles. For the timing checks it also samples one cycle before and one cycle after each event. Expected capture values come from the same edge count as (edges / 32) mod 250, including values on both sides of the wrap.

// File: rtl/tbcw_pkg.sv
package tbcw_pkg;
    // Control/status bit positions (software-visible layout)
    localparam int CSR_ICIE = 7;
    localparam int CSR_ICF  = 6;
    localparam int CSR_LONG = 5;
    localparam int CSR_TBIE = 4;
    localparam int CSR_TBF  = 3;
    localparam int CSR_WRF  = 2;
    localparam int CSR_WEN  = 1;
    localparam int CSR_WDL  = 0;

    typedef struct packed {
        logic icie;
        logic tb_long;
        logic tbie;
        logic tbf;
        logic wrf;
        logic wen;
        logic wdl;
        logic armed;
        logic rst_req;
    } ctrl_t;
endpackage

// File: rtl/tbcw_timebase.sv
module tbcw_timebase #(
    parameter int PRESCALE = 32,
    parameter int CNT_TOP  = 249,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             half_o
);
    localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0]  PS_MAX = PS_W'(PRESCALE - 1);
    localparam logic [CNT_W-1:0] TOP    = CNT_W'(CNT_TOP);

    typedef struct packed {
        logic [PS_W-1:0]  ps;
        logic [CNT_W-1:0] cnt;
        logic             half;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic tick;

    always_comb begin
        st_d  = st_q;
        tick  = (st_q.ps == PS_MAX);
        ovf_o = tick && (st_q.cnt == TOP);
        if (tick) begin
            st_d.ps  = '0;
            st_d.cnt = (st_q.cnt == TOP) ? '0 : st_q.cnt + 1'b1;
        end else begin
            st_d.ps = st_q.ps + 1'b1;
        end
        if (ovf_o) st_d.half = ~st_q.half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign half_o = st_q.half;

    // R3: counter never leaves its range and wraps to zero after the top value
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= TOP);
    p_cnt_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (st_q.cnt == '0));
endmodule

// File: rtl/tbcw_capture.sv
module tbcw_capture #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             icr_rd_i,
    output logic [CNT_W-1:0] icr_o,
    output logic             icf_o
);
    typedef struct packed {
        logic [2:0]       sync;
        logic [CNT_W-1:0] icr;
        logic             icf;
    } cap_state_t;

    cap_state_t cs_d, cs_q;
    logic edge_seen;

    always_comb begin
        cs_d      = cs_q;
        cs_d.sync = {cs_q.sync[1:0], pin_i};
        edge_seen = cs_q.sync[1] ^ cs_q.sync[2];
        if (icr_rd_i) cs_d.icf = 1'b0;
        if (edge_seen && !cs_q.icf) begin
            cs_d.icr = cnt_i;
            cs_d.icf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign icr_o = cs_q.icr;
    assign icf_o = cs_q.icf;

    // R7: a pending capture freezes the captured value
    p_icr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.icf |=> $stable(cs_q.icr));
    // R7: the flag only drops when the capture register is read
    p_icf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.icf && !icr_rd_i) |=> cs_q.icf);
endmodule

// File: rtl/tbcw_timer.sv
module tbcw_timer
    import tbcw_pkg::*;
#(
    parameter int          PRESCALE = 32,
    parameter int          CNT_TOP  = 249,
    parameter int          CNT_W    = 8,
    parameter logic [7:0]  CSR_ADDR = 8'h0B,
    parameter logic [7:0]  ICR_ADDR = 8'h0C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvr_i,
    input  logic       bus_sel_i,
    input  logic       bus_wr_i,
    input  logic       bus_rd_i,
    input  logic [7:0] bus_addr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    input  logic       cap_pin_i,
    output logic       tb_irq_o,
    output logic       cap_irq_o,
    output logic       wdg_rst_o
);
    logic [CNT_W-1:0] cnt, icr;
    logic ovf, half, icf;
    logic csr_rd, csr_wr, icr_rd;
    logic tb_set, wd_end, expire, force_rst;
    logic [7:0] icr_byte, csr_byte;
    ctrl_t c_d, c_q;

    tbcw_timebase #(.PRESCALE(PRESCALE), .CNT_TOP(CNT_TOP), .CNT_W(CNT_W)) timebase_i (
        .clk(clk), .rst_n(rst_n), .cnt_o(cnt), .ovf_o(ovf), .half_o(half));

    tbcw_capture #(.CNT_W(CNT_W)) capture_i (
        .clk(clk), .rst_n(rst_n), .pin_i(cap_pin_i), .cnt_i(cnt),
        .icr_rd_i(icr_rd), .icr_o(icr), .icf_o(icf));

    assign csr_rd = bus_sel_i && bus_rd_i && (bus_addr_i == CSR_ADDR);
    assign csr_wr = bus_sel_i && bus_wr_i && (bus_addr_i == CSR_ADDR);
    assign icr_rd = bus_sel_i && bus_rd_i && (bus_addr_i == ICR_ADDR);

    always_comb begin
        c_d       = c_q;
        tb_set    = ovf && (!c_q.tb_long || half);
        wd_end    = ovf && half;
        expire    = wd_end && c_q.wen && !c_q.wdl;
        force_rst = csr_wr && bus_wdata_i[CSR_WRF];

        if (csr_wr) begin
            c_d.icie    = bus_wdata_i[CSR_ICIE];
            c_d.tb_long = bus_wdata_i[CSR_LONG];
            c_d.tbie    = bus_wdata_i[CSR_TBIE];
            c_d.wen     = bus_wdata_i[CSR_WEN];
            if (bus_wdata_i[CSR_WDL]) c_d.wdl = 1'b1;
            if (!bus_wdata_i[CSR_WRF] && c_q.armed) c_d.wrf = 1'b0;
            c_d.armed = 1'b0;
        end else if (csr_rd) begin
            c_d.armed = 1'b1;
        end

        if (csr_rd) c_d.tbf = 1'b0;
        if (tb_set) c_d.tbf = 1'b1;
        if (wd_end) c_d.wdl = 1'b0;

        c_d.rst_req = expire || force_rst;
        if (expire || force_rst) c_d.wrf = 1'b1;
        if (lvr_i) c_d.wrf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        icr_byte = '0;
        icr_byte[CNT_W-1:0] = icr;
        csr_byte = '0;
        csr_byte[CSR_ICIE] = c_q.icie;
        csr_byte[CSR_ICF]  = icf;
        csr_byte[CSR_LONG] = c_q.tb_long;
        csr_byte[CSR_TBIE] = c_q.tbie;
        csr_byte[CSR_TBF]  = c_q.tbf;
        csr_byte[CSR_WRF]  = c_q.wrf;
        csr_byte[CSR_WEN]  = c_q.wen;
        csr_byte[CSR_WDL]  = c_q.wdl;
        if (bus_addr_i == CSR_ADDR)      bus_rdata_o = csr_byte;
        else if (bus_addr_i == ICR_ADDR) bus_rdata_o = icr_byte;
        else                             bus_rdata_o = '0;
    end

    assign tb_irq_o  = c_q.tbf && c_q.tbie;
    assign cap_irq_o = icf && c_q.icie;
    assign wdg_rst_o = c_q.rst_req;

    // R4: the timebase flag only rises after a counter overflow
    p_tbf_from_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.tbf) |-> $past(ovf));
    // R5: without a status read the timebase flag stays set
    p_tbf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.tbf && !csr_rd) |=> c_q.tbf);
    // R10: the delay bit is gone after every period end
    p_wdl_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wd_end |=> !c_q.wdl);
    // R9: a reset request is always recorded in the flag unless low-voltage clears it
    p_req_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wdg_rst_o && !$past(lvr_i)) |-> c_q.wrf);
    // R12: the low-voltage input always leaves the flag clear
    p_lvr_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        lvr_i |=> !c_q.wrf);
endmodule

// File: tb/tbcw_timer_tb.sv
module tbcw_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lvr = 1'b0;
    logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;
    logic       pin = 1'b0;
    logic       tb_irq, cap_irq, wdg_rst;
    int         cyc = 0;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    localparam logic [7:0] A_CSR = 8'h0B;
    localparam logic [7:0] A_ICR = 8'h0C;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    tbcw_timer dut_i (
        .clk(clk), .rst_n(rst_n), .lvr_i(lvr),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .cap_pin_i(pin), .tb_irq_o(tb_irq), .cap_irq_o(cap_irq),
        .wdg_rst_o(wdg_rst));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", req, cyc, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; addr = 8'h00;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        sel = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0; rd = 1'b0; addr = 8'h00;
    endtask

    function automatic int cnt_at(input int e);
        return (e / 32) % 250;
    endfunction

    // Toggle the pin at cycle c (ICIE set) and check the capture path end to end
    task automatic cap_check(input int c, input logic [7:0] csr_exp);
        logic [7:0] v;
        wait_cyc(c);
        pin = ~pin;
        wait_cyc(c + 2);
        check("R6 capture not early", cap_irq, 0);
        wait_cyc(c + 3);
        check("R8 cap_irq with flag and enable", cap_irq, 1);
        wait_cyc(c + 4);
        bus_read(A_CSR, v);
        check("R2 CSR shows capture flag", v, csr_exp);
        bus_read(A_ICR, v);
        check("R3 R6 captured counter", v, cnt_at(c + 2));
        check("R7 cap_irq drops after ICR read", cap_irq, 0);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 tb_irq reset", tb_irq, 0);
        check("R1 cap_irq reset", cap_irq, 0);
        check("R1 wdg_rst reset", wdg_rst, 0);
        bus_read(A_CSR, v); check("R1 CSR reset", v, 8'h00);
        bus_read(A_ICR, v); check("R1 ICR reset", v, 8'h00);
        bus_read(8'h0D, v); check("R2 unmapped address", v, 8'h00);
        bus_write(A_CSR, 8'h90);

        for (int i = 0; i < 16; i++) cap_check(200 + i * 317, 8'hD0);
        cap_check(7990, 8'hD0);

        wait_cyc(7999); check("R4 no timebase before 8000", tb_irq, 0);
        wait_cyc(8000); check("R4 R8 timebase at 8000", tb_irq, 1);
        bus_read(A_CSR, v); check("R2 R4 CSR with TBF", v, 8'h98);
        check("R5 read clears TBF", tb_irq, 0);

        cap_check(8010, 8'hD0);   // counter wrapped: 0

        // R7 edges while pending are ignored, writes cannot clear the flag
        wait_cyc(8100); pin = ~pin;
        wait_cyc(8200); pin = ~pin;
        wait_cyc(8250); bus_write(A_CSR, 8'h90);
        wait_cyc(8260); bus_read(A_CSR, v); check("R7 write leaves ICF", v, 8'hD0);
        wait_cyc(8300); bus_read(A_ICR, v); check("R7 second edge ignored", v, cnt_at(8102));
        bus_read(A_CSR, v); check("R7 ICF cleared by ICR read", v, 8'h90);

        wait_cyc(8400); bus_write(A_CSR, 8'h98);
        bus_read(A_CSR, v); check("R5 write cannot set TBF", v, 8'h90);
        check("R5 tb_irq stays low", tb_irq, 0);

        // R8 capture without enable
        wait_cyc(8500); bus_write(A_CSR, 8'h10);
        wait_cyc(8600); pin = ~pin;
        wait_cyc(8610); check("R8 cap_irq masked", cap_irq, 0);
        bus_read(A_CSR, v); check("R6 ICF set while masked", v, 8'h50);
        bus_read(A_ICR, v); check("R3 R6 capture masked", v, cnt_at(8602));

        // R4 long period
        wait_cyc(8700); bus_write(A_CSR, 8'hB0);
        wait_cyc(15999); check("R4 long: none before 16000", tb_irq, 0);
        wait_cyc(16000); check("R4 long: flag at 16000", tb_irq, 1);
        check("R9 disabled watchdog silent", wdg_rst, 0);
        bus_read(A_CSR, v); check("R4 CSR at 16000", v, 8'hB8);
        wait_cyc(24001); check("R4 long: skip 24000", tb_irq, 0);
        bus_read(A_CSR, v); check("R4 CSR at 24001", v, 8'hB0);
        wait_cyc(32000); check("R4 long: flag at 32000", tb_irq, 1);
        check("R9 disabled watchdog silent 2", wdg_rst, 0);
        bus_read(A_CSR, v);

        // R9 watchdog expiry
        wait_cyc(32100); bus_write(A_CSR, 8'hB2);
        wait_cyc(47999); check("R9 no request early", wdg_rst, 0);
        wait_cyc(48000); check("R9 request at period end", wdg_rst, 1);
        wait_cyc(48001); check("R9 request one cycle", wdg_rst, 0);
        wait_cyc(48002); bus_read(A_CSR, v); check("R9 flag set", v, 8'hBE);
        // R12 armed clear plus R10 delay
        bus_write(A_CSR, 8'hB3);
        wait_cyc(48005); bus_read(A_CSR, v); check("R10 R12 delay set, flag cleared", v, 8'hB3);
        wait_cyc(64000); check("R10 delayed: no request", wdg_rst, 0);
        wait_cyc(64001); bus_read(A_CSR, v); check("R10 delay cleared by period end", v, 8'hBA);
        wait_cyc(64010); bus_write(A_CSR, 8'hB2);
        wait_cyc(80000); check("R10 next period resets", wdg_rst, 1);
        wait_cyc(80001); bus_write(A_CSR, 8'hB2);
        bus_write(A_CSR, 8'hB2);
        bus_read(A_CSR, v); check("R12 unarmed write keeps flag", v, 8'hBE);
        bus_write(A_CSR, 8'hB0);
        bus_read(A_CSR, v); check("R12 armed write clears flag", v, 8'hB0);
        // R11 forced request
        wait_cyc(80010); bus_write(A_CSR, 8'hB4);
        check("R11 forced request", wdg_rst, 1);
        @(negedge clk); check("R11 forced request one cycle", wdg_rst, 0);
        bus_read(A_CSR, v); check("R11 flag after force", v, 8'hB4);
        // R12 low-voltage clear
        wait_cyc(80020); lvr = 1'b1;
        @(negedge clk); lvr = 1'b0;
        bus_read(A_CSR, v); check("R12 lvr clears flag", v, 8'hB0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: run hung at cycle %0d, expected end before 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule